// File: doc/BRIEF.md
# Flash Program/Erase Protection Guard

This block sits between the CPU bus and the flash high-voltage sequencer. It holds the program, erase, mass-erase and high-voltage enable controls. It grants the high-voltage enable only when two conditions hold. First, the software has read the protect byte after arming an operation. Second, the captured protect bits do not lock any address that the operation would reach. A conflict found during that read disarms the operation, so no high-voltage pulse reaches the array.

The protect byte is an input that reflects the stored nonvolatile value. The guard captures its low four bits whenever the CPU reads the protect address, and neither that byte nor the captured copy is cleared by reset. Each set protect bit locks a range that ends at 0x7FEF, plus the 16-byte vector area 0xFFF0–0xFFFF. Any operation that would reach the protect byte at 0xFFF0 needs the test-voltage input. The bus here is a plain single-cycle register port; it has no back-pressure and no handshake.

Top module: `flash_guard`

## Requirements
- R1: After reset, pgm, erase, mass and hv_en are 0 and no protect snapshot is valid.
- R2: A write to CTRL_ADDR (0xFE08) loads bit0 as program, bit1 as erase and bit2 as mass. Reading CTRL_ADDR returns {4'b0, hv_en, mass, erase, pgm}. Reads of any other address, and cycles with no read, return 0.
- R3: A read of PROT_ADDR (0xFFF0) returns {4'b0, prot_byte[3:0]} and captures prot_byte[3:0]. The upper four bits are ignored.
- R4: A control write with bit3 set raises hv_en on the next cycle only if all of these hold: exactly one of program or erase is armed; the written arm bits equal the current ones; a protect read happened while armed with no invalidation since; and the captured bits, the current target and tvolt show no conflict. Otherwise hv_en stays 0.
- R5: A control write that changes the arm bits invalidates the snapshot. A change of tgt_addr invalidates the snapshot and clears hv_en on the next cycle.
- R6: A protect read while an operation is armed that shows a conflict (using the byte being read) clears pgm, erase, mass and hv_en on the next cycle.
- R7: Bit0, bit1, bit2 and bit3 lock from 0x7800, 0x7880, 0x7900 and 0x7A00 respectively, through 0x7FEF, plus 0xFFF0–0xFFFF. With several bits set, the lowest start applies. A zero nibble locks nothing.
- R8: Program targets one byte. Erase targets the aligned 64-byte page holding tgt_addr. Erase with mass targets 0x0000–0xFFFF.
- R9: An operation whose extent includes 0xFFF0 conflicts unless tvolt is 1. With tvolt at 1, the protect bits do not lock 0xFFF0–0xFFFF.
- R10: A control write with bit3 clear drops hv_en on the next cycle.
- R11: With program and erase both set, nothing is armed: a protect read validates nothing, and hv_en is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| prot_byte | input | 8 | Stored protect byte value |
| tgt_addr | input | 16 | Target address of the pending operation |
| tvolt | input | 1 | External test voltage present |
| pgm | output | 1 | Program armed |
| erase | output | 1 | Erase armed |
| mass | output | 1 | Mass-erase flag |
| hv_en | output | 1 | High-voltage enable to sequencer |

## Verification
The embedded assertions check on every cycle that hv_en only rises from a valid, conflict-free snapshot, and never while tvolt is missing for an operation that reaches the protect byte. They also check that hv_en always accompanies exactly one armed operation, and that conflicting reads, target changes and HVEN-clear writes take effect one cycle later. Whether the lock boundaries sit at the right addresses, and whether page and mass extents are computed correctly, can only be shown by the bench's scenarios. So can the outcome of a missed or stale protect read. These scenarios walk each protect bit across its start address and probe 0x7FEF, 0x7FF0, 0xFFEF and 0xFFF0 against a behavioural reference.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_BYTE = 2'd1,
    OP_PAGE = 2'd2,
    OP_ALL  = 2'd3
  } op_kind_t;
endpackage

// File: rtl/fg_range.sv
// Computes the inclusive address extent touched by the armed operation.
module fg_range
  import fg_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PAGE_W = 6
) (
  input  logic [AW-1:0] addr,
  input  op_kind_t      kind,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi
);
  always_comb begin
    case (kind)
      OP_PAGE: begin
        lo = {addr[AW-1:PAGE_W], {PAGE_W{1'b0}}};
        hi = {addr[AW-1:PAGE_W], {PAGE_W{1'b1}}};
      end
      OP_ALL: begin
        lo = '0;
        hi = '1;
      end
      default: begin
        lo = addr;
        hi = addr;
      end
    endcase
  end
endmodule

// File: rtl/fg_lock.sv
// Compares an extent against the ranges locked by a protect nibble.
module fg_lock #(
  parameter int AW        = 16,
  parameter int NB        = 4,
  parameter int MAIN_BASE = 16'h7800,
  parameter int MAIN_END  = 16'h7FEF,
  parameter int STEP      = 16'h0080,
  parameter int VEC_BASE  = 16'hFFF0,
  parameter int PB_ADDR   = 16'hFFF0
) (
  input  logic [NB-1:0] bits,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          tvolt,
  output logic          conflict,
  output logic          touch_pb
);
  localparam logic [AW-1:0] END_A = AW'(MAIN_END);
  localparam logic [AW-1:0] VEC_A = AW'(VEC_BASE);
  localparam logic [AW-1:0] PB_A  = AW'(PB_ADDR);

  function automatic logic [AW-1:0] bit_start(input int k);
    if (k == 0) return AW'(MAIN_BASE);
    return AW'(MAIN_BASE + (STEP << (k - 1)));
  endfunction

  logic          any_set;
  logic [AW-1:0] start;
  logic          hit_main, hit_vec;

  always_comb begin
    any_set = |bits;
    start   = END_A;
    for (int k = NB - 1; k >= 0; k--) begin
      if (bits[k]) start = bit_start(k);
    end
  end

  assign hit_main = any_set && (lo <= END_A) && (hi >= start);
  assign hit_vec  = any_set && (hi >= VEC_A) && !tvolt;
  assign touch_pb = (lo <= PB_A) && (hi >= PB_A);
  assign conflict = hit_main || hit_vec || (touch_pb && !tvolt);

  // R7
  always_comb begin
    zero_nibble_open_chk: assert (!((bits == '0) && !touch_pb && conflict));
  end
endmodule

// File: rtl/fg_ctrl.sv
// Control bits, snapshot latch, snapshot validity and HVEN gating.
module fg_ctrl #(
  parameter int AW = 16,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          rd_prot,
  input  logic [2:0]    wbits,
  input  logic          whv,
  input  logic [AW-1:0] tgt_addr,
  input  logic [NB-1:0] prot_nib,
  input  logic          conflict_live,
  input  logic          conflict_snap,
  input  logic          touch_pb,
  input  logic          tvolt,
  output logic [NB-1:0] latch_q,
  output logic          pgm,
  output logic          erase,
  output logic          mass,
  output logic          hven
);
  logic          snap_valid;
  logic [AW-1:0] tgt_q;
  logic          tgt_chg, armed, hv_ok;
  logic [2:0]    cur_bits;

  assign cur_bits = {mass, erase, pgm};
  assign tgt_chg  = (tgt_addr != tgt_q);
  assign armed    = pgm ^ erase;
  assign hv_ok    = armed && snap_valid && !tgt_chg &&
                    (wbits == cur_bits) && !conflict_snap;

  // Snapshot latch and target tracker carry no reset.
  always_ff @(posedge clk) begin
    tgt_q <= tgt_addr;
    if (rd_prot) latch_q <= prot_nib;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm        <= 1'b0;
      erase      <= 1'b0;
      mass       <= 1'b0;
      hven       <= 1'b0;
      snap_valid <= 1'b0;
    end else begin
      if (tgt_chg) begin
        snap_valid <= 1'b0;
        hven       <= 1'b0;
      end
      if (wr_ctrl) begin
        {mass, erase, pgm} <= wbits;
        if (wbits != cur_bits) snap_valid <= 1'b0;
        hven <= whv && hv_ok;
      end else if (rd_prot && armed) begin
        snap_valid <= 1'b1;
        if (conflict_live) begin
          pgm   <= 1'b0;
          erase <= 1'b0;
          mass  <= 1'b0;
          hven  <= 1'b0;
        end
      end
    end
  end

  // R4
  hv_needs_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hven) |-> ($past(snap_valid) && !$past(conflict_snap)));
  // R11
  hv_single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hven |-> (pgm ^ erase));
  // R6
  read_conflict_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_prot && !wr_ctrl && armed && conflict_live) |=> (!pgm && !erase && !hven));
  // R5
  tgt_change_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_chg |=> !hven);
  // R9
  tvolt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hven) |-> ($past(tvolt) || !$past(touch_pb)));
  // R10
  hv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !whv) |=> !hven);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int NB        = 4,
  parameter int PAGE_W    = 6,
  parameter int CTRL_ADDR = 16'hFE08,
  parameter int PROT_ADDR = 16'hFFF0,
  parameter int MAIN_BASE = 16'h7800,
  parameter int MAIN_END  = 16'h7FEF,
  parameter int STEP      = 16'h0080,
  parameter int VEC_BASE  = 16'hFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] prot_byte,
  input  logic [AW-1:0] tgt_addr,
  input  logic          tvolt,
  output logic          pgm,
  output logic          erase,
  output logic          mass,
  output logic          hv_en
);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] PROT_A = AW'(PROT_ADDR);
  localparam int NSRC = 2;

  logic          wr_ctrl, rd_ctrl, rd_prot;
  logic [NB-1:0] latch_q;
  logic [NB-1:0] src_bits [NSRC];
  logic          src_conf [NSRC];
  logic          src_pb   [NSRC];
  op_kind_t      kind;
  logic [AW-1:0] t_lo, t_hi;

  assign wr_ctrl = bus_sel && bus_we && (bus_addr == CTRL_A);
  assign rd_ctrl = bus_sel && !bus_we && (bus_addr == CTRL_A);
  assign rd_prot = bus_sel && !bus_we && (bus_addr == PROT_A);

  always_comb begin
    if (pgm && !erase)      kind = OP_BYTE;
    else if (erase && !pgm) kind = mass ? OP_ALL : OP_PAGE;
    else                    kind = OP_NONE;
  end

  fg_range #(.AW(AW), .PAGE_W(PAGE_W)) u_range (
    .addr (tgt_addr),
    .kind (kind),
    .lo   (t_lo),
    .hi   (t_hi)
  );

  // Source 0: byte on the bus right now; source 1: captured snapshot.
  assign src_bits[0] = prot_byte[NB-1:0];
  assign src_bits[1] = latch_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_lock
    fg_lock #(
      .AW(AW), .NB(NB), .MAIN_BASE(MAIN_BASE), .MAIN_END(MAIN_END),
      .STEP(STEP), .VEC_BASE(VEC_BASE), .PB_ADDR(PROT_ADDR)
    ) u_lock (
      .bits     (src_bits[g]),
      .lo       (t_lo),
      .hi       (t_hi),
      .tvolt    (tvolt),
      .conflict (src_conf[g]),
      .touch_pb (src_pb[g])
    );
  end

  fg_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ctrl       (wr_ctrl),
    .rd_prot       (rd_prot),
    .wbits         (bus_wdata[2:0]),
    .whv           (bus_wdata[3]),
    .tgt_addr      (tgt_addr),
    .prot_nib      (prot_byte[NB-1:0]),
    .conflict_live (src_conf[0]),
    .conflict_snap (src_conf[1]),
    .touch_pb      (src_pb[1]),
    .tvolt         (tvolt),
    .latch_q       (latch_q),
    .pgm           (pgm),
    .erase         (erase),
    .mass          (mass),
    .hven          (hv_en)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_prot)      bus_rdata[NB-1:0] = prot_byte[NB-1:0];
    else if (rd_ctrl) bus_rdata[3:0]    = {hv_en, mass, erase, pgm};
  end

  // R3
  always_comb begin
    rsvd_zero_chk: assert (!(rd_prot && (bus_rdata[DW-1:NB] != '0)));
  end
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam logic [15:0] CTRL = 16'hFE08;
  localparam logic [15:0] PB   = 16'hFFF0;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [15:0] bus_addr = 0, tgt_addr = 0;
  logic [7:0] bus_wdata = 0, prot_byte = 0, bus_rdata;
  logic tvolt = 0;
  logic pgm, erase, mass, hv_en;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  // reference model state
  bit m_p, m_e, m_m, m_hv, m_valid;
  int m_latch, m_tq;

  always #5 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prot_byte(prot_byte), .tgt_addr(tgt_addr), .tvolt(tvolt),
    .pgm(pgm), .erase(erase), .mass(mass), .hv_en(hv_en)
  );

  function automatic bit m_conflict(int nib, int a, bit p, bit e, bit m, bit tv);
    int lo, hi, st;
    if (p) begin lo = a; hi = a; end
    else if (m) begin lo = 0; hi = 65535; end
    else begin lo = (a / 64) * 64; hi = lo + 63; end
    if (nib[0]) st = 'h7800;
    else if (nib[1]) st = 'h7880;
    else if (nib[2]) st = 'h7900;
    else st = 'h7A00;
    if (nib != 0 && lo <= 'h7FEF && hi >= st) return 1;
    if (nib != 0 && hi >= 'hFFF0 && !tv) return 1;
    if (lo <= 'hFFF0 && hi >= 'hFFF0 && !tv) return 1;
    return 0;
  endfunction

  function automatic int m_rdata();
    if (bus_sel && !bus_we && bus_addr == PB) return prot_byte & 'hF;
    if (bus_sel && !bus_we && bus_addr == CTRL)
      return (m_hv << 3) | (m_m << 2) | (m_e << 1) | m_p;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit chg, wr, rd, armed, same;
    int nb;
    chg = (tgt_addr != m_tq);
    m_tq = tgt_addr;
    wr = bus_sel && bus_we && bus_addr == CTRL;
    rd = bus_sel && !bus_we && bus_addr == PB;
    if (rd) nb = prot_byte & 'hF;
    else nb = 0;
    if (!rst_n) begin
      m_p = 0; m_e = 0; m_m = 0; m_hv = 0; m_valid = 0;
      if (rd) m_latch = nb;
    end else begin
      armed = m_p ^ m_e;
      if (chg) begin m_valid = 0; m_hv = 0; end
      if (wr) begin
        same = (bus_wdata[2:0] == {m_m, m_e, m_p});
        m_hv = bus_wdata[3] && armed && m_valid && !chg && same &&
               !m_conflict(m_latch, tgt_addr, m_p, m_e, m_m, tvolt);
        if (!same) m_valid = 0;
        {m_m, m_e, m_p} = bus_wdata[2:0];
      end else if (rd) begin
        m_latch = nb;
        if (armed) begin
          m_valid = 1;
          if (m_conflict(nb, tgt_addr, m_p, m_e, m_m, tvolt)) begin
            m_p = 0; m_e = 0; m_m = 0; m_hv = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 hv_en per-cycle", hv_en, m_hv);
      chk("R6 arm bits per-cycle", {mass, erase, pgm}, {m_m, m_e, m_p});
      chk("R2 rdata per-cycle", bus_rdata, m_rdata());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic bus_w(input logic [15:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_r(input logic [15:0] a);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    cyc();
    bus_sel = 0;
  endtask

  // kind: 1 = program, 2 = page erase, 6 = mass erase, 3 = both
  task automatic run_op(input logic [2:0] kind, input logic [15:0] a,
                        input logic [7:0] pb, input bit tv, input bit exp,
                        input string tag);
    tgt_addr = a; prot_byte = pb; tvolt = tv;
    cyc();
    bus_w(CTRL, {5'b0, kind});
    bus_r(PB);
    bus_w(CTRL, {5'b00001, kind});
    chk(tag, hv_en, exp);
    bus_w(CTRL, 8'h00);
    chk("R10 hv dropped by clear", hv_en, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    #1;
    cmp_on = 1;
    chk("R1 reset hv_en", hv_en, 0);
    chk("R1 reset arm", {mass, erase, pgm}, 0);

    run_op(3'd1, 16'h7800, 8'h00, 0, 1, "R4 correct sequence open");

    // missing protect read
    tgt_addr = 16'h7000; cyc();
    bus_w(CTRL, 8'h01);
    bus_w(CTRL, 8'h09);
    chk("R4 no read refused", hv_en, 0);
    bus_w(CTRL, 8'h00);

    // each protect bit against its start address
    run_op(3'd1, 16'h77FF, 8'h01, 0, 1, "R7 bit0 below start");
    run_op(3'd1, 16'h7800, 8'h01, 0, 0, "R7 bit0 at start");
    run_op(3'd1, 16'h787F, 8'h02, 0, 1, "R7 bit1 below start");
    run_op(3'd1, 16'h7880, 8'h02, 0, 0, "R7 bit1 at start");
    run_op(3'd1, 16'h78FF, 8'h04, 0, 1, "R7 bit2 below start");
    run_op(3'd1, 16'h7900, 8'h04, 0, 0, "R7 bit2 at start");
    run_op(3'd1, 16'h79FF, 8'h08, 0, 1, "R7 bit3 below start");
    run_op(3'd1, 16'h7A00, 8'h08, 0, 0, "R7 bit3 at start");
    run_op(3'd1, 16'h7880, 8'h0A, 0, 0, "R7 union lowest start");
    run_op(3'd1, 16'h7FEF, 8'h08, 0, 0, "R7 top of main range");
    run_op(3'd1, 16'h7FF0, 8'h08, 0, 1, "R7 above main range");
    run_op(3'd1, 16'hFFEF, 8'h08, 0, 1, "R7 below vector area");
    run_op(3'd1, 16'hFFF5, 8'h08, 0, 0, "R7 vector area locked");

    // R6 explicit: conflicting read disarms
    tgt_addr = 16'h7A10; prot_byte = 8'h08; cyc();
    bus_w(CTRL, 8'h01);
    bus_r(PB);
    chk("R6 conflict clears pgm", pgm, 0);

    // extents
    run_op(3'd2, 16'hFFEF, 8'h08, 0, 0, "R8 page erase reaches vectors");
    run_op(3'd2, 16'h7FC5, 8'h08, 0, 0, "R8 page overlaps 7FEF");
    run_op(3'd2, 16'h77C0, 8'h01, 0, 1, "R8 page below lock");
    run_op(3'd6, 16'h1234, 8'h00, 1, 1, "R8 mass open with tvolt");
    run_op(3'd6, 16'h1234, 8'h01, 1, 0, "R8 mass blocked by bit");

    // test voltage
    run_op(3'd6, 16'h1234, 8'h00, 0, 0, "R9 mass without tvolt");
    run_op(3'd2, 16'hFFC0, 8'h00, 0, 0, "R9 protect page without tvolt");
    run_op(3'd2, 16'hFFC0, 8'h00, 1, 1, "R9 protect page with tvolt");
    run_op(3'd1, 16'hFFF0, 8'h08, 1, 1, "R9 protect byte with tvolt");
    run_op(3'd1, 16'hFFF0, 8'h00, 0, 0, "R9 protect byte no tvolt");
    tvolt = 0;

    // reserved bits
    tgt_addr = 16'h7A00; prot_byte = 8'hF0; cyc();
    bus_sel = 1; bus_we = 0; bus_addr = PB; #2;
    chk("R3 reserved bits read zero", bus_rdata, 8'h00);
    cyc(); bus_sel = 0;
    run_op(3'd1, 16'h7A00, 8'hF0, 0, 1, "R3 reserved bits no lock");

    // invalidation
    tgt_addr = 16'h7000; prot_byte = 8'h00; cyc();
    bus_w(CTRL, 8'h01);
    bus_r(PB);
    tgt_addr = 16'h7001; cyc();
    bus_w(CTRL, 8'h09);
    chk("R5 target change invalidates", hv_en, 0);
    bus_w(CTRL, 8'h00);
    bus_w(CTRL, 8'h01);
    bus_r(PB);
    bus_w(CTRL, 8'h02);
    bus_w(CTRL, 8'h0A);
    chk("R5 arm change invalidates", hv_en, 0);
    bus_w(CTRL, 8'h00);

    // target change while hv high
    tgt_addr = 16'h7000; cyc();
    bus_w(CTRL, 8'h01);
    bus_r(PB);
    bus_w(CTRL, 8'h09);
    chk("R4 granted before change", hv_en, 1);
    tgt_addr = 16'h7002; cyc();
    chk("R5 target change drops hv", hv_en, 0);
    bus_w(CTRL, 8'h00);

    run_op(3'd3, 16'h7000, 8'h00, 0, 0, "R11 both bits refused");

    // control readback
    bus_w(CTRL, 8'h01);
    bus_r(PB);
    bus_w(CTRL, 8'h09);
    bus_sel = 1; bus_we = 0; bus_addr = CTRL; #2;
    chk("R2 ctrl readback", bus_rdata, 8'h09);
    bus_addr = 16'h1234; #1;
    chk("R2 other address reads zero", bus_rdata, 8'h00);
    cyc(); bus_sel = 0;

    // reset while granted
    rst_n = 0; cyc();
    chk("R1 reset drops hv", hv_en, 0);
    chk("R1 reset disarms", {mass, erase, pgm}, 0);
    rst_n = 1; cyc();
    bus_w(CTRL, 8'h01);
    bus_w(CTRL, 8'h09);
    chk("R1 snapshot invalid after reset", hv_en, 0);
    cyc();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule